// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder Model

This block is a synthesizable model of the device side of a two-bank SDRAM command port. It serves as a target for memory-controller tests. On every rising clock edge it samples chip select, the three strobe lines, the address bus and an output-enable input. It decodes the command, updates the state of each bank, and streams read data back through a latency pipeline that the mode register sets. Read data is not stored. Each word is computed from its bank, row and column. A bench can therefore predict every word without a memory array.

Each bank is either idle or open on a row. A per-bank counter enforces the minimum activate-to-read delay. The burst engine produces one column per cycle. It wraps within an aligned block for fixed burst lengths, and for full-page bursts it runs until something stops it. A new read can take over the engine on any cycle, which gives a gapless stream. Commands that break the rules are ignored, and an error pulse is raised.

Top module: `sdram_cmd_model`

## Requirements
- R1: After reset, both banks are idle, the mode is unprogrammed, `dq_drive` is 0, `dq_out` is 0 and `err` is 0.
- R2: When `cs_n` is high, the strobes and address have no effect. The strobe code {ras_n,cas_n,we_n}=111 (NOP), and the write and refresh codes, also do nothing.
- R3: Activate ({ras_n,cas_n,we_n}=011) to an idle bank opens the row on `addr[10:0]` in the bank selected by `addr[11]`. Activate to an already open bank is ignored and raises `err` for one cycle after the command edge.
- R4: Mode set (code 000) loads the burst code from `addr[2:0]` and the latency code from `addr[5:4]`. A latency code of 0 counts as 1. Until the first mode set, every read is rejected with `err` and produces no data.
- R5: Read (code 101 with `addr[10]`=0) addresses column `addr[7:0]` of bank `addr[11]`. It is accepted only if that bank is open and at least TRCD (default 3) edges have passed since its activate. Otherwise the read is ignored and `err` pulses.
- R6: The first word of an accepted read is driven the programmed latency L edges after the read edge. When L is 2 or more, nothing is driven before that.
- R7: Burst codes 0, 1, 2 and 3 give 1, 2, 4 and 8 words. Columns increment and wrap inside the aligned block of that size. Each word equals {row[7:0], column} and is inverted bitwise for bank 1. Driving stops after the last word.
- R8: A read accepted while a burst is running replaces that burst at once, so the two streams join with no idle cycle.
- R9: Burst codes 4 to 7 select a full-page burst, which wraps over 256 columns without end. A burst stop (code 110) issues no further words from its edge onwards.
- R10: Precharge (code 010) closes bank `addr[11]`, or both banks when `addr[10]`=1. It halts a running burst only if that burst's bank is closed.
- R11: `dq_oe` is sampled on each edge. While the sampled value is 0, `dq_drive` and `dq_out` are 0, but the burst keeps advancing.
- R12: A read with `addr[10]`=1 is ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Row, column, bank and mode opcode |
| dq_oe | input | 1 | Output enable, sampled each edge |
| dq_out | output | 16 | Read data, 0 when not driving |
| dq_drive | output | 1 | High when `dq_out` carries a word |
| err | output | 1 | One-cycle pulse after a rejected command |

## Verification
The hardest cases are the stop conditions of a running full-page burst. The bench must tell a burst stop, a precharge to the burst's own bank and a precharge to the other bank apart, counting the words already in the latency pipeline. To reach them, the bench first opens both banks and programs full-page mode. It starts a read near the column wrap point, so the wrap is checked as well. It then issues each stop command a known number of cycles after the read and checks that the stream ends on exactly the predicted word. The activate-to-read limit is probed with reads on consecutive edges after an activate: two of them must be rejected and the third accepted.

// File: rtl/sdrm_pkg.sv
package sdrm_pkg;

   typedef enum logic [2:0] {
      C_NOP,
      C_ACT,
      C_READ,
      C_PRE,
      C_BST,
      C_MRS
   } cmd_e;

   // Strobe decode; write and refresh codes fall through to NOP.
   function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n,
                                       input logic a10);
      cmd_e c;
      c = C_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  c = C_ACT;
            3'b101:  c = a10 ? C_NOP : C_READ;
            3'b010:  c = C_PRE;
            3'b110:  c = C_BST;
            3'b000:  c = C_MRS;
            default: c = C_NOP;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/sdrm_bank.sv
module sdrm_bank #(
   parameter int ROW_W = 11,
   parameter int TRCD  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             pre,
   input  logic [ROW_W-1:0] row_in,
   output logic             active,
   output logic             ready,
   output logic [ROW_W-1:0] row_q
);
   localparam int CNT_W = (TRCD < 2) ? 1 : $clog2(TRCD);

   logic [CNT_W-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         row_q    <= '0;
         wait_cnt <= '0;
      end else if (act) begin
         active   <= 1'b1;
         row_q    <= row_in;
         wait_cnt <= CNT_W'(TRCD - 1);
      end else begin
         if (pre) active <= 1'b0;
         if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      end
   end

   assign ready = active && (wait_cnt == '0);

   assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> (active && row_q == $past(row_in)));
   assert_act_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> !active);
   assert_pre_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pre && !act) |=> !active);
endmodule

// File: rtl/sdrm_burst.sv
module sdrm_burst #(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 8,
   parameter int MAX_CL = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_bank,
   input  logic [ROW_W-1:0] start_row,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             stop_bst,
   input  logic [1:0]       pre_hit,
   input  logic [1:0]       cl,
   output logic             word_valid,
   output logic             word_bank,
   output logic [ROW_W-1:0] word_row,
   output logic [COL_W-1:0] word_col
);
   localparam int WORD_W = 2 + ROW_W + COL_W;

   logic             live, full, v0, bank_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q, mask_q, col_nx;
   logic [2:0]       rem_q;
   logic             stop;
   logic [WORD_W-1:0] issue_w, sel_w;
   logic [WORD_W-1:0] pipe [MAX_CL];

   assign stop   = stop_bst || pre_hit[bank_q];
   assign col_nx = (col_q & ~mask_q) | ((col_q + 1'b1) & mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= 1'b0; full <= 1'b0; v0 <= 1'b0; bank_q <= 1'b0;
         row_q <= '0; col_q <= '0; mask_q <= '0; rem_q <= '0;
      end else if (start) begin
         live   <= 1'b1;
         v0     <= 1'b1;
         bank_q <= start_bank;
         row_q  <= start_row;
         col_q  <= start_col;
         full   <= len_code[2];
         mask_q <= len_code[2] ? '1 : COL_W'((8'd1 << len_code[1:0]) - 8'd1);
         rem_q  <= len_code[2] ? 3'd0 : 3'((4'd1 << len_code[1:0]) - 4'd1);
      end else if (live && !stop && (full || rem_q != 3'd0)) begin
         v0    <= 1'b1;
         col_q <= col_nx;
         if (!full) rem_q <= rem_q - 1'b1;
      end else begin
         live <= 1'b0;
         v0   <= 1'b0;
      end
   end

   assign issue_w = {v0, bank_q, row_q, col_q};

   // Latency line: stage i holds the word issued i edges earlier.
   always_comb pipe[0] = issue_w;
   for (genvar gi = 1; gi < MAX_CL; gi++) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[gi] <= '0;
         else        pipe[gi] <= pipe[gi-1];
      end
   end

   always_comb begin
      sel_w = pipe[0];
      for (int i = 1; i < MAX_CL; i++)
         if (cl == 2'(i + 1)) sel_w = pipe[i];
   end

   assign {word_valid, word_bank, word_row, word_col} = sel_w;

   assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (live && stop && !start) |=> !v0);
   assert_fixed_len_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (v0 && !full && rem_q == 3'd0 && !start) |=> !v0);
   assert_start_issues_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (v0 && col_q == $past(start_col)));
endmodule

// File: rtl/sdram_cmd_model.sv
module sdram_cmd_model
   import sdrm_pkg::*;
#(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 8,
   parameter int DATA_W = 16,
   parameter int TRCD   = 3,
   parameter int MAX_CL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ROW_W:0]    addr,
   input  logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drive,
   output logic              err
);
   localparam int RC_W = ROW_W + COL_W;

   if (COL_W < 3 || COL_W > ROW_W - 1) begin : g_bad_col
      $error("COL_W must lie in 3..ROW_W-1");
   end
   if (ROW_W < 7) begin : g_bad_row
      $error("ROW_W must be at least 7 to hold the mode fields");
   end
   if (MAX_CL < 1 || MAX_CL > 3) begin : g_bad_cl
      $error("MAX_CL must lie in 1..3");
   end
   if (TRCD < 1) begin : g_bad_trcd
      $error("TRCD must be at least 1");
   end

   cmd_e             cmd;
   logic             sel_bank, a10;
   logic [1:0]       bank_act, bank_rdy, act_v, pre_v;
   logic [ROW_W-1:0] bank_row [2];
   logic             mode_set, oe_q;
   logic [2:0]       bl_code;
   logic [1:0]       cl_q, cl_in;
   logic             rd_ok, rd_bad, act_bad;
   logic             w_valid, w_bank;
   logic [ROW_W-1:0] w_row;
   logic [COL_W-1:0] w_col;
   logic [RC_W-1:0]  rc;
   logic [DATA_W-1:0] raw;

   assign sel_bank = addr[ROW_W];
   assign a10      = addr[ROW_W-1];
   assign cmd      = decode_cmd(cs_n, ras_n, cas_n, we_n, a10);

   for (genvar b = 0; b < 2; b++) begin : g_bank
      assign act_v[b] = (cmd == C_ACT) && (sel_bank == 1'(b)) && !bank_act[b];
      assign pre_v[b] = (cmd == C_PRE) && (a10 || sel_bank == 1'(b));
      sdrm_bank #(.ROW_W(ROW_W), .TRCD(TRCD)) u_bank (
         .clk(clk), .rst_n(rst_n), .act(act_v[b]), .pre(pre_v[b]),
         .row_in(addr[ROW_W-1:0]), .active(bank_act[b]),
         .ready(bank_rdy[b]), .row_q(bank_row[b]));
   end

   assign act_bad = (cmd == C_ACT) && bank_act[sel_bank];
   assign rd_ok   = (cmd == C_READ) && mode_set && bank_rdy[sel_bank];
   assign rd_bad  = (cmd == C_READ) && !rd_ok;

   always_comb begin
      cl_in = (addr[5:4] == 2'd0) ? 2'd1 : addr[5:4];
      if (int'(cl_in) > MAX_CL) cl_in = 2'(MAX_CL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_set <= 1'b0;
         bl_code  <= '0;
         cl_q     <= 2'd1;
         err      <= 1'b0;
         oe_q     <= 1'b0;
      end else begin
         err  <= act_bad || rd_bad;
         oe_q <= dq_oe;
         if (cmd == C_MRS) begin
            mode_set <= 1'b1;
            bl_code  <= addr[2:0];
            cl_q     <= cl_in;
         end
      end
   end

   sdrm_burst #(.ROW_W(ROW_W), .COL_W(COL_W), .MAX_CL(MAX_CL)) u_burst (
      .clk(clk), .rst_n(rst_n), .start(rd_ok), .start_bank(sel_bank),
      .start_row(bank_row[sel_bank]), .start_col(addr[COL_W-1:0]),
      .len_code(bl_code), .stop_bst(cmd == C_BST), .pre_hit(pre_v),
      .cl(cl_q), .word_valid(w_valid), .word_bank(w_bank),
      .word_row(w_row), .word_col(w_col));

   assign rc = {w_row, w_col};
   if (DATA_W <= RC_W) begin : g_trunc
      assign raw = rc[DATA_W-1:0];
   end else begin : g_ext
      assign raw = {{(DATA_W-RC_W){1'b0}}, rc};
   end

   assign dq_drive = w_valid && oe_q;
   assign dq_out   = dq_drive ? (raw ^ {DATA_W{w_bank}}) : '0;

   assert_read_idle_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == C_READ) && !bank_act[sel_bank]) |=> err);
   assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!err && $stable(bank_act)));
   assert_no_data_unset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive |-> mode_set);
   assert_a10_read_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && {ras_n, cas_n, we_n} == 3'b101 && a10) |=> !err);
endmodule

// File: tb/sdram_cmd_model_test.sv
module sdram_cmd_model_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [11:0] addr = '0;
   logic        dq_oe = 1'b1;
   logic [15:0] dq_out;
   logic        dq_drive, err;

   int vectors = 0, miscompares = 0, cur_cl = 1;
   bit done = 0;

   always #10 clk = ~clk;

   sdram_cmd_model uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .addr(addr), .dq_oe(dq_oe),
      .dq_out(dq_out), .dq_drive(dq_drive), .err(err));

   function automatic logic [15:0] pat(input bit b, input logic [10:0] r,
                                       input logic [7:0] c);
      return {r[7:0], c} ^ {16{b}};
   endfunction

   task automatic issue(input logic [3:0] code, input logic [11:0] a);
      {cs_n, ras_n, cas_n, we_n} = code;
      addr = a;
      @(negedge clk);
   endtask
   task automatic nop();                   issue(4'b0111, 12'h000); endtask
   task automatic act(input bit b, input logic [10:0] r); issue(4'b0011, {b, r}); endtask
   task automatic rd(input bit b, input logic [7:0] c);   issue(4'b0101, {b, 3'b000, c}); endtask
   task automatic pre(input bit b, input bit all);        issue(4'b0010, {b, all, 10'h0}); endtask
   task automatic bst();                   issue(4'b0110, 12'h000); endtask
   task automatic mrs(input int cl, input logic [2:0] bl);
      issue(4'b0000, {6'h0, 2'(cl), 1'b0, bl});
      cur_cl = (cl == 0) ? 1 : cl;
   endtask

   task automatic see(input bit drv, input logic [15:0] d, input string tag);
      vectors++;
      if (dq_drive !== drv || (drv && dq_out !== d)) begin
         miscompares++;
         $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                  tag, dq_drive, dq_out, drv, d);
      end
   endtask

   task automatic chk_err(input bit e, input string tag);
      vectors++;
      if (err !== e) begin
         miscompares++;
         $display("FAIL %s: err=%0b expected %0b", tag, err, e);
      end
   endtask

   // Call just after a read edge; checks the whole stream and its end.
   task automatic stream(input bit b, input logic [10:0] r, input logic [7:0] c0,
                         input int n, input logic [7:0] mask, input string tag);
      for (int i = 0; i < cur_cl - 1; i++) begin
         see(0, 16'h0, {tag, " lead"});
         nop();
      end
      for (int i = 0; i < n; i++) begin
         see(1, pat(b, r, (c0 & ~mask) | (8'(c0 + i) & mask)), tag);
         nop();
      end
      see(0, 16'h0, {tag, " tail"});
   endtask

   task automatic t_reset();
      see(0, 16'h0, "R1 reset drive");
      chk_err(0, "R1 reset err");
   endtask

   task automatic t_no_mode();
      act(0, 11'h005); nop(); nop(); nop();
      rd(0, 8'h00);
      chk_err(1, "R4 read before mode set");
      for (int i = 0; i < 4; i++) begin see(0, 16'h0, "R4 no data"); nop(); end
   endtask

   task automatic t_deselect();
      issue(4'b1011, {1'b1, 11'h033});
      chk_err(0, "R2 deselected activate");
      mrs(2, 3'd2); nop(); nop(); nop();
      rd(1, 8'h00);
      chk_err(1, "R2 bank1 stayed idle (R5 idle read)");
      issue(4'b1101, 12'h000);
      chk_err(0, "R2 deselected read");
      for (int i = 0; i < 3; i++) begin see(0, 16'h0, "R2 no data"); nop(); end
      issue(4'b0100, 12'h000); chk_err(0, "R2 write code ignored");
      issue(4'b0001, 12'h000); chk_err(0, "R2 refresh code ignored");
      see(0, 16'h0, "R2 quiet");
   endtask

   task automatic t_act_twice();
      act(0, 11'h0A9);
      chk_err(1, "R3 activate open bank");
      nop();
      chk_err(0, "R3 err one cycle");
      rd(0, 8'h20);
      stream(0, 11'h005, 8'h20, 4, 8'h03, "R3 row kept / R7 len4");
   endtask

   task automatic t_latency();
      mrs(3, 3'd2);
      rd(0, 8'h46);
      stream(0, 11'h005, 8'h46, 4, 8'h03, "R6 latency3 / R7 wrap4");
      mrs(0, 3'd0);
      rd(0, 8'h13);
      stream(0, 11'h005, 8'h13, 1, 8'h00, "R6 latency1 / R7 len1");
      mrs(2, 3'd3);
      rd(0, 8'h3D);
      stream(0, 11'h005, 8'h3D, 8, 8'h07, "R7 len8 wrap");
   endtask

   task automatic t_trcd();
      mrs(2, 3'd1);
      pre(0, 0);
      act(0, 11'h012);
      rd(0, 8'h00); chk_err(1, "R5 read 1 edge after activate");
      rd(0, 8'h00); chk_err(1, "R5 read 2 edges after activate");
      rd(0, 8'h00); chk_err(0, "R5 read 3 edges after activate");
      stream(0, 11'h012, 8'h00, 2, 8'h01, "R5 accepted read");
   endtask

   task automatic t_gapless();
      rd(0, 8'h10);
      see(0, 16'h0, "R8 lead");
      nop();
      see(1, pat(0, 11'h012, 8'h10), "R8 word0");
      rd(0, 8'h30);
      see(1, pat(0, 11'h012, 8'h11), "R8 word1");
      nop();
      see(1, pat(0, 11'h012, 8'h30), "R8 joined word2");
      nop();
      see(1, pat(0, 11'h012, 8'h31), "R8 joined word3");
      nop();
      see(0, 16'h0, "R8 end");
   endtask

   task automatic t_fullpage();
      mrs(2, 3'd7);
      rd(0, 8'hFE);
      nop(); see(1, pat(0, 11'h012, 8'hFE), "R9 word0");
      nop(); see(1, pat(0, 11'h012, 8'hFF), "R9 word1");
      nop(); see(1, pat(0, 11'h012, 8'h00), "R9 page wrap");
      nop(); see(1, pat(0, 11'h012, 8'h01), "R9 word3");
      bst(); see(1, pat(0, 11'h012, 8'h02), "R9 last word in pipe");
      nop(); see(0, 16'h0, "R9 stopped");
      nop(); see(0, 16'h0, "R9 stays stopped");
   endtask

   task automatic t_precharge();
      act(1, 11'h044); nop(); nop(); nop();
      rd(0, 8'h80);
      nop(); see(1, pat(0, 11'h012, 8'h80), "R10 word0");
      pre(1, 0); see(1, pat(0, 11'h012, 8'h81), "R10 word1");
      nop(); see(1, pat(0, 11'h012, 8'h82), "R10 other bank kept burst");
      pre(0, 0); see(1, pat(0, 11'h012, 8'h83), "R10 word3");
      nop(); see(0, 16'h0, "R10 own bank stopped");
      rd(0, 8'h00); chk_err(1, "R10 bank0 closed");
      act(0, 11'h001); act(1, 11'h002); nop(); nop(); nop();
      pre(0, 1);
      rd(0, 8'h00); chk_err(1, "R10 all-bank close bank0");
      rd(1, 8'h00); chk_err(1, "R10 all-bank close bank1");
   endtask

   task automatic t_oe();
      act(1, 11'h0C3); nop(); nop(); nop();
      rd(1, 8'h05);
      nop(); see(1, pat(1, 11'h0C3, 8'h05), "R11 word0 bank1");
      dq_oe = 1'b0;
      nop(); see(0, 16'h0, "R11 masked");
      dq_oe = 1'b1;
      nop(); see(1, pat(1, 11'h0C3, 8'h07), "R11 burst advanced");
      bst(); see(1, pat(1, 11'h0C3, 8'h08), "R11 word3");
      nop(); see(0, 16'h0, "R11 end");
   endtask

   task automatic t_a10read();
      issue(4'b0101, {1'b1, 1'b1, 2'b00, 8'h00});
      chk_err(0, "R12 auto-precharge read no err");
      for (int i = 0; i < 3; i++) begin see(0, 16'h0, "R12 no data"); nop(); end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_mode();
      t_deselect();
      t_act_twice();
      t_latency();
      t_trcd();
      t_gapless();
      t_fullpage();
      t_precharge();
      t_oe();
      t_a10read();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule